// File: doc/BRIEF.md
# Transmit Start and Collision Retry Controller

This block sequences the sending of one frame that already sits in local buffer memory. A one-cycle command pulse latches a start page and a byte count and clears the transmit status. The block then enables prefetch from memory and waits until the line may be used. While the frame is on the wire it steps a DMA address for each byte that leaves. When the frame ends cleanly it sets a done flag and goes back to idle.

A collision during the frame rewinds the block. It resets the FIFO, restores the DMA address and byte count to the frame start, counts the collision and starts an external backoff timer. The retry waits for that timer. On the sixteenth collision, which is the fifteenth retransmission that also collides, the block gives up and sets an abort flag. The serial MAC, the backoff random source and the memory are outside the block and are seen only as plain inputs.

Top module: `txr_top`

## Requirements
- R1: After reset, txPending, txEn, prefetchEn, fifoReset, ptrRestore, backoffStart, statusDone, statusAbort and statusCol are 0, and colCount is 0.
- R2: A txCmd pulse while idle latches startPage and byteCount, clears statusDone, statusAbort, statusCol and colCount, and raises txPending from the next cycle. A txCmd pulse while txPending is 1 has no effect on the status, colCount or dmaAddr.
- R3: prefetchEn is 1 only while txPending is 1, rxBusy is 0 and the block is not yielding under R5.
- R4: txEn rises one cycle after a cycle in the waiting state in which gapDone=1, fifoNotEmpty=1 and rxBusy=0 all hold. It never rises otherwise.
- R5: While waiting to start, carrierSense=1 with fifoNotEmpty=0 forces prefetchEn to 0 and keeps txEn at 0. The command stays pending.
- R6: A collision while txEn=1 drives fifoReset and ptrRestore to 1 in that same cycle. In the next cycle dmaAddr equals {startPage, 8'h00} and the byte count is reloaded.
- R7: Each collision that does not abort sets statusCol, increments colCount by one, pulses backoffStart in that same cycle and drops txEn.
- R8: After a collision, txEn stays 0 until backoffDone has been seen. The retry then starts under the conditions of R4.
- R9: A collision while colCount is 15 aborts the frame. statusAbort=1, statusCol=1, colCount reads 0, txPending=0, and there is no backoffStart pulse.
- R10: When byteSent has been seen byteCount times since the last restore with no collision, statusDone becomes 1 and txPending falls in the same cycle.
- R11: dmaAddr equals {startPage, 8'h00} plus the number of byteSent pulses accepted since the last load or restore.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPage | input | 8 | Buffer page holding the frame start |
| byteCount | input | 16 | Frame length in bytes, at least 1 |
| txCmd | input | 1 | One-cycle transmit command |
| gapDone | input | 1 | Interframe-gap timer has expired |
| fifoNotEmpty | input | 1 | At least one byte is waiting in the FIFO |
| collision | input | 1 | Collision seen on the line |
| carrierSense | input | 1 | Carrier present on the line |
| rxBusy | input | 1 | A receive is in progress |
| backoffDone | input | 1 | Backoff timer has expired |
| byteSent | input | 1 | One byte has left for the line |
| txPending | output | 1 | Command bit, clears itself on completion or abort |
| prefetchEn | output | 1 | Permit prefetch from memory |
| txEn | output | 1 | Frame is being transmitted |
| fifoReset | output | 1 | Flush FIFO strobe |
| ptrRestore | output | 1 | Rewind DMA pointers strobe |
| backoffStart | output | 1 | Start backoff timer strobe |
| dmaAddr | output | 16 | Current transmit DMA address |
| statusDone | output | 1 | Frame completed |
| statusAbort | output | 1 | Frame aborted after excessive collisions |
| statusCol | output | 1 | At least one collision occurred |
| colCount | output | 4 | Collision counter |

## Verification
The properties assume two things about the inputs. The environment never asserts byteSent and collision in the same cycle. byteCount is never zero when a command is issued. The stimulus drives every input on the falling edge and raises at most one event per cycle. It only issues collisions after at least one byte has gone and before the last one, using frames of two or more bytes. Backoff expiry, carrier and receive activity come only as directed pulses held across single cycles, so each waiting condition is seen on its own.

// File: rtl/txr_pkg.sv
package txr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_SEND,
    ST_BACKOFF
  } txrState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic advance;
    logic restore;
    logic colInc;
    logic abort;
    logic done;
  } txrStrobe_t;

endpackage

// File: rtl/txr_ctrl.sv
module txr_ctrl
  import txr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       txCmd,
  input  logic       gapDone,
  input  logic       fifoNotEmpty,
  input  logic       collision,
  input  logic       carrierSense,
  input  logic       rxBusy,
  input  logic       backoffDone,
  input  logic       byteSent,
  input  logic       lastByte,
  input  logic       colMax,
  output txrStrobe_t strobe,
  output logic       txPending,
  output logic       prefetchEn,
  output logic       txEn,
  output logic       fifoReset,
  output logic       ptrRestore,
  output logic       backoffStart
);

  txrState_e state, stateNext;
  logic yieldLine;

  assign yieldLine = carrierSense && !fifoNotEmpty;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext    = state;
    strobe       = '0;
    fifoReset    = 1'b0;
    ptrRestore   = 1'b0;
    backoffStart = 1'b0;
    prefetchEn   = 1'b0;
    txEn         = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (txCmd) begin
          strobe.load = 1'b1;
          stateNext   = ST_WAIT;
        end
      end
      ST_WAIT: begin
        prefetchEn = !rxBusy && !yieldLine;
        if (gapDone && fifoNotEmpty && !rxBusy) stateNext = ST_SEND;
      end
      ST_SEND: begin
        txEn       = 1'b1;
        prefetchEn = !rxBusy;
        if (collision) begin
          fifoReset      = 1'b1;
          ptrRestore     = 1'b1;
          strobe.restore = 1'b1;
          if (colMax) begin
            strobe.abort = 1'b1;
            stateNext    = ST_IDLE;
          end else begin
            strobe.colInc = 1'b1;
            backoffStart  = 1'b1;
            stateNext     = ST_BACKOFF;
          end
        end else if (byteSent) begin
          strobe.advance = 1'b1;
          if (lastByte) begin
            strobe.done = 1'b1;
            stateNext   = ST_IDLE;
          end
        end
      end
      ST_BACKOFF: begin
        prefetchEn = !rxBusy;
        if (backoffDone) stateNext = ST_WAIT;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign txPending = (state != ST_IDLE);

endmodule

// File: rtl/txr_dp.sv
module txr_dp
  import txr_pkg::*;
#(
  parameter int PAGE_W = 8,
  parameter int CNT_W  = 16,
  parameter int COL_W  = 4,
  localparam int ADDR_W = PAGE_W + 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  txrStrobe_t        strobe,
  input  logic [PAGE_W-1:0] startPage,
  input  logic [CNT_W-1:0]  byteCount,
  output logic              lastByte,
  output logic              colMax,
  output logic [ADDR_W-1:0] dmaAddr,
  output logic              statusDone,
  output logic              statusAbort,
  output logic              statusCol,
  output logic [COL_W-1:0]  colCount
);

  logic [ADDR_W-1:0] frameBase;
  logic [CNT_W-1:0]  frameLen;
  logic [CNT_W-1:0]  remaining;

  assign lastByte = (remaining == CNT_W'(1));
  assign colMax   = (colCount == {COL_W{1'b1}});

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameBase <= '0;
      frameLen  <= '0;
      remaining <= '0;
      dmaAddr   <= '0;
    end else if (strobe.load) begin
      frameBase <= {startPage, 8'h00};
      dmaAddr   <= {startPage, 8'h00};
      frameLen  <= byteCount;
      remaining <= byteCount;
    end else if (strobe.restore) begin
      dmaAddr   <= frameBase;
      remaining <= frameLen;
    end else if (strobe.advance) begin
      dmaAddr   <= dmaAddr + ADDR_W'(1);
      remaining <= remaining - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.load) begin
      statusDone  <= 1'b0;
      statusAbort <= 1'b0;
      statusCol   <= 1'b0;
      colCount    <= '0;
    end else begin
      if (strobe.done) statusDone <= 1'b1;
      if (strobe.colInc) begin
        statusCol <= 1'b1;
        colCount  <= colCount + COL_W'(1);
      end
      if (strobe.abort) begin
        statusAbort <= 1'b1;
        statusCol   <= 1'b1;
        colCount    <= '0;
      end
    end
  end

endmodule

// File: rtl/txr_top.sv
module txr_top
  import txr_pkg::*;
#(
  parameter int PAGE_W = 8,
  parameter int CNT_W  = 16,
  parameter int COL_W  = 4,
  localparam int ADDR_W = PAGE_W + 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PAGE_W-1:0] startPage,
  input  logic [CNT_W-1:0]  byteCount,
  input  logic              txCmd,
  input  logic              gapDone,
  input  logic              fifoNotEmpty,
  input  logic              collision,
  input  logic              carrierSense,
  input  logic              rxBusy,
  input  logic              backoffDone,
  input  logic              byteSent,
  output logic              txPending,
  output logic              prefetchEn,
  output logic              txEn,
  output logic              fifoReset,
  output logic              ptrRestore,
  output logic              backoffStart,
  output logic [ADDR_W-1:0] dmaAddr,
  output logic              statusDone,
  output logic              statusAbort,
  output logic              statusCol,
  output logic [COL_W-1:0]  colCount
);

  txrStrobe_t strobe;
  logic lastByte;
  logic colMax;

  txr_ctrl u_ctrl (
    .clk, .rstN, .txCmd, .gapDone, .fifoNotEmpty, .collision, .carrierSense,
    .rxBusy, .backoffDone, .byteSent, .lastByte, .colMax, .strobe,
    .txPending, .prefetchEn, .txEn, .fifoReset, .ptrRestore, .backoffStart
  );

  txr_dp #(.PAGE_W(PAGE_W), .CNT_W(CNT_W), .COL_W(COL_W)) u_dp (
    .clk, .rstN, .strobe, .startPage, .byteCount, .lastByte, .colMax,
    .dmaAddr, .statusDone, .statusAbort, .statusCol, .colCount
  );

endmodule

// File: rtl/txr_checker.sv
module txr_checker #(
  parameter int ADDR_W = 16,
  parameter int COL_W  = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              collision,
  input logic              fifoNotEmpty,
  input logic              rxBusy,
  input logic              txPending,
  input logic              prefetchEn,
  input logic              txEn,
  input logic              fifoReset,
  input logic              ptrRestore,
  input logic              backoffStart,
  input logic [ADDR_W-1:0] dmaAddr,
  input logic              statusDone,
  input logic              statusAbort,
  input logic              statusCol,
  input logic [COL_W-1:0]  colCount
);

  a_r3_prefetch_quiet: assert property (@(posedge clk) disable iff (!rstN)
    prefetchEn |-> (!rxBusy && txPending));

  a_r4_start_needs_data: assert property (@(posedge clk) disable iff (!rstN)
    (!txEn && !fifoNotEmpty) |=> !txEn);

  a_r6_rewind_strobes: assert property (@(posedge clk) disable iff (!rstN)
    (txEn && collision) |-> (fifoReset && ptrRestore));

  a_r6_addr_at_base: assert property (@(posedge clk) disable iff (!rstN)
    ptrRestore |=> (dmaAddr[7:0] == 8'h00));

  a_r7_backoff_marks_col: assert property (@(posedge clk) disable iff (!rstN)
    backoffStart |=> (statusCol && !txEn));

  a_r9_abort_clears_count: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusAbort) |-> (colCount == '0 && !txPending && statusCol));

  a_r10_done_clean: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusDone) |-> (!txPending && !statusAbort));

endmodule

bind txr_top txr_checker #(.ADDR_W(ADDR_W), .COL_W(COL_W)) u_chk (
  .clk(clk), .rstN(rstN), .collision(collision), .fifoNotEmpty(fifoNotEmpty),
  .rxBusy(rxBusy), .txPending(txPending), .prefetchEn(prefetchEn),
  .txEn(txEn), .fifoReset(fifoReset), .ptrRestore(ptrRestore),
  .backoffStart(backoffStart), .dmaAddr(dmaAddr), .statusDone(statusDone),
  .statusAbort(statusAbort), .statusCol(statusCol), .colCount(colCount)
);

// File: tb/txr_top_bench.sv
module txr_top_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  startPage = '0;
  logic [15:0] byteCount = '0;
  logic txCmd = 0, gapDone = 0, fifoNotEmpty = 0, collision = 0;
  logic carrierSense = 0, rxBusy = 0, backoffDone = 0, byteSent = 0;
  logic txPending, prefetchEn, txEn, fifoReset, ptrRestore, backoffStart;
  logic [15:0] dmaAddr;
  logic statusDone, statusAbort, statusCol;
  logic [3:0] colCount;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  typedef struct packed {
    logic        done;
    logic        abort;
    logic        col;
    logic [3:0]  cnt;
    logic [15:0] addr;
  } result_t;

  result_t expQ[$];

  always #5 clk = ~clk;

  txr_top u_txr_top (
    .clk, .rstN, .startPage, .byteCount, .txCmd, .gapDone, .fifoNotEmpty,
    .collision, .carrierSense, .rxBusy, .backoffDone, .byteSent,
    .txPending, .prefetchEn, .txEn, .fifoReset, .ptrRestore, .backoffStart,
    .dmaAddr, .statusDone, .statusAbort, .statusCol, .colCount
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: compare final status when the command bit self-clears
  logic prevPending = 1'b0;
  always @(negedge clk) begin
    if (rstN && prevPending && !txPending) begin
      result_t got, want;
      got = {statusDone, statusAbort, statusCol, colCount, dmaAddr};
      if (expQ.size() == 0) begin
        checks++; errors++;
        $display("FAIL R10: actual %0h expected none (unexpected end)", got);
      end else begin
        want = expQ.pop_front();
        check("R10/R9/R11 frame end", 32'(got), 32'(want));
      end
    end
    prevPending <= txPending;
  end

  task automatic issueCmd(input logic [7:0] pg, input logic [15:0] cnt);
    @(negedge clk);
    startPage = pg; byteCount = cnt; txCmd = 1'b1;
    @(negedge clk);
    txCmd = 1'b0;
    check("R2 pending", 32'(txPending), 1);
    check("R2 status cleared", 32'({statusDone, statusAbort, statusCol, colCount}), 0);
  endtask

  // expects state WAIT with start conditions presented
  task automatic runBody(input logic [7:0] pg, input logic [15:0] cnt,
                         input int nCol, input bit poke);
    result_t want;
    if (nCol >= 16)
      want = {1'b0, 1'b1, 1'b1, 4'd0, pg, 8'h00};
    else
      want = {1'b1, 1'b0, (nCol > 0), 4'(nCol), 16'({pg, 8'h00} + cnt)};
    expQ.push_back(want);
    @(negedge clk);
    check("R4 txEn up", 32'(txEn), 1);
    if (poke) begin
      txCmd = 1'b1; startPage = pg + 8'h11;
      @(negedge clk);
      txCmd = 1'b0;
      check("R2 ignored cmd keeps addr", 32'(dmaAddr), 32'({pg, 8'h00}));
      check("R2 ignored cmd keeps pending", 32'(txPending), 1);
    end
    for (int a = 0; a < nCol && a < 16; a++) begin
      byteSent = 1'b1;
      @(negedge clk);
      byteSent = 1'b0;
      check("R11 addr step", 32'(dmaAddr), 32'({pg, 8'h01}));
      collision = 1'b1;
      #1;
      check("R6 rewind strobes", 32'({fifoReset, ptrRestore}), 3);
      check("R7 backoffStart", 32'(backoffStart), (a < 15) ? 1 : 0);
      @(negedge clk);
      collision = 1'b0;
      check("R6 addr restored", 32'(dmaAddr), 32'({pg, 8'h00}));
      check("R7 colCount", 32'(colCount), (a < 15) ? 32'(a + 1) : 0);
      check("R7 col bit", 32'(statusCol), 1);
      if (a == 15) begin
        check("R9 abort", 32'({statusAbort, txPending}), 2);
        return;
      end
      check("R8 txEn low in backoff", 32'(txEn), 0);
      @(negedge clk);
      check("R8 txEn waits for backoff", 32'(txEn), 0);
      backoffDone = 1'b1;
      @(negedge clk);
      backoffDone = 1'b0;
      @(negedge clk);
      check("R8 retry txEn", 32'(txEn), 1);
    end
    for (int i = 0; i < int'(cnt); i++) begin
      byteSent = 1'b1;
      @(negedge clk);
      byteSent = 1'b0;
    end
    check("R10 done and idle", 32'({statusDone, txPending}), 2);
    check("R11 final addr", 32'(dmaAddr), 32'({pg, 8'h00} + cnt));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset outputs", 32'({txPending, prefetchEn, txEn, fifoReset, ptrRestore,
          backoffStart, statusDone, statusAbort, statusCol, colCount}), 0);
    rstN = 1'b1;

    // clean frame
    gapDone = 1; fifoNotEmpty = 1;
    issueCmd(8'h40, 16'd4);
    runBody(8'h40, 16'd4, 0, 1'b0);

    // receive in progress holds prefetch and start (R3)
    rxBusy = 1;
    issueCmd(8'h12, 16'd3);
    #1 check("R3 prefetch off while rx", 32'(prefetchEn), 0);
    @(negedge clk);
    check("R4 no start while rx", 32'(txEn), 0);
    rxBusy = 0;
    #1 check("R3 prefetch on", 32'(prefetchEn), 1);
    runBody(8'h12, 16'd3, 0, 1'b0);

    // carrier with empty FIFO yields (R5)
    fifoNotEmpty = 0; carrierSense = 1;
    issueCmd(8'h20, 16'd2);
    #1 check("R5 prefetch yields", 32'(prefetchEn), 0);
    @(negedge clk);
    check("R5 no start", 32'(txEn), 0);
    check("R5 still pending", 32'(txPending), 1);
    carrierSense = 0;
    #1 check("R3 prefetch resumes", 32'(prefetchEn), 1);
    @(negedge clk);
    check("R4 no start with empty FIFO", 32'(txEn), 0);
    fifoNotEmpty = 1;
    runBody(8'h20, 16'd2, 0, 1'b0);

    // collisions then success, plus ignored command
    issueCmd(8'h33, 16'd5);
    runBody(8'h33, 16'd5, 2, 1'b1);

    // excessive collisions
    issueCmd(8'h7a, 16'd6);
    runBody(8'h7a, 16'd6, 16, 1'b0);

    // new command after abort clears status
    issueCmd(8'h05, 16'd2);
    runBody(8'h05, 16'd2, 0, 1'b0);

    repeat (3) @(negedge clk);
    if (expQ.size() != 0) begin
      checks++; errors++;
      $display("FAIL R10: actual %0d pending results expected 0", expQ.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule